// File: doc/BRIEF.md
# Amplifier Protection Fault Supervisor

This block is the central fault manager for a class-D power stage. It takes nine digitised comparator levels: a thermal warning, two temperature limits, overcurrent, supply overvoltage, supply and logic-rail undervoltage, the output window, PLL lock and PLL underfrequency. All inputs are assumed to be synchronous to `clk`. From them it keeps one fault state per protection class. It drives an open-drain diagnostic request, decides whether the output stage switches or floats, and keeps sticky per-fault status flags that a register interface can clear with a write strobe.

Faults fall into two recovery families. The overtemperature and overcurrent faults clear by themselves once their condition has been absent for a programmable number of clocks, and that count starts over if the condition comes back. All other faults clear as soon as their own restart condition is met. The thermal warning never shuts the stage down. Instead it walks the output gain down one step at a time, and once the warning ends it walks the gain back up to the user setting at the same rate.

Top module: `amp_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it goes high, all fault states are inactive and the outputs read `diag_pull_low_o`=0, `out_float_o`=0, `flags_o`=0 and `gain_o`=0.
- R2: The overtemperature fault (`ot_hot_i`) and the overcurrent fault (`oc_i`) become active on the first edge that samples their input high. Each stays active until RECOV_CYC consecutive edges have sampled the input low, and a high sample during that wait restarts the count.
- R3: The overvoltage fault becomes active on an edge sampling `ov_i` high. The undervoltage fault becomes active on an edge sampling `vdd_low_i` or `rail_low_i` high. Each clears only on an edge where its own trigger is low and both `vdd_low_i` and `rail_low_i` are low. Otherwise it holds.
- R4: The overdissipation fault is active after an edge sampling `od_temp_i` and `oc_i` both high. It clears on the first edge where either of them is low.
- R5: The window fault (`win_i`), the lock-loss fault (`pll_unlock_i`) and the underfrequency fault (`pll_slow_i`) each follow their input, registered by one edge.
- R6: `diag_pull_low_o` is 1 exactly when any of the overtemperature, overcurrent, overvoltage, undervoltage, overdissipation or window faults is active. The two PLL faults and the thermal warning never drive it.
- R7: `out_float_o` is 1 exactly when any of the eight faults is active. The thermal warning alone never floats the stage.
- R8: `flags_o` bit positions are 0 overtemperature, 1 overcurrent, 2 overvoltage, 3 undervoltage, 4 overdissipation, 5 window, 6 lock loss, 7 underfrequency. A bit is set on any edge that samples its fault's trigger condition. It stays set until an edge samples the matching `flag_clr_i` bit high while the trigger is absent. When both happen on the same edge, the set wins.
- R9: A step tick occurs on every STEP_CYC-th functional edge after reset. While `tw_hot_i` is sampled high, each tick lowers `gain_o` by one, and the gain stops at 0.
- R10: While `tw_hot_i` is sampled low, each tick raises `gain_o` by one until it reaches `vol_set_i`. On any edge where `gain_o` exceeds `vol_set_i`, the gain is set to `vol_set_i` at once, so it never exceeds the setting sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tw_hot_i | input | 1 | Thermal warning comparator |
| ot_hot_i | input | 1 | Overtemperature comparator |
| oc_i | input | 1 | Overcurrent comparator |
| ov_i | input | 1 | Supply overvoltage comparator |
| vdd_low_i | input | 1 | Main supply below its minimum |
| rail_low_i | input | 1 | Logic rail below its minimum |
| od_temp_i | input | 1 | Temperature above the overdissipation limit |
| win_i | input | 1 | Output outside the allowed window |
| pll_unlock_i | input | 1 | PLL out of lock |
| pll_slow_i | input | 1 | PLL frequency below its minimum |
| flag_clr_i | input | 8 | Clear-on-write strobe, one bit per flag |
| vol_set_i | input | GAIN_W | User gain setting |
| diag_pull_low_o | output | 1 | 1 = pull the open-drain diagnostic pin low |
| out_float_o | output | 1 | 1 = output stage floats |
| flags_o | output | 8 | Sticky fault flags |
| gain_o | output | GAIN_W | Gain after thermal foldback |

## Verification
The bench builds the block with RECOV_CYC=8, STEP_CYC=4 and GAIN_W=6. With a recovery wait of eight clocks, random toggling of the comparators often re-asserts a timed fault in the middle of its countdown, and it also often lets the countdown run to the end. A four-clock step with a six-bit gain lets a full ramp to a setting of 20, a foldback to zero and a recovery all fit inside a few hundred cycles. It also lets random warning pulses catch the gain partway through its ramps. A cycle-accurate model built from the requirements is compared with every output on every cycle.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;

  localparam int unsigned NUM_FAULTS = 8;

  localparam int unsigned FI_OT    = 0;
  localparam int unsigned FI_OC    = 1;
  localparam int unsigned FI_OV    = 2;
  localparam int unsigned FI_UV    = 3;
  localparam int unsigned FI_OD    = 4;
  localparam int unsigned FI_WIN   = 5;
  localparam int unsigned FI_LOCK  = 6;
  localparam int unsigned FI_UFREQ = 7;

  typedef enum logic {
    REC_TIMED   = 1'b0,
    REC_RESTART = 1'b1
  } recov_kind_e;

  // faults allowed to pull the diagnostic pin low
  localparam logic [NUM_FAULTS-1:0] DIAG_ROUTE = 8'b0011_1111;

  function automatic recov_kind_e kind_of(int unsigned idx);
    return (idx == FI_OT || idx == FI_OC) ? REC_TIMED : REC_RESTART;
  endfunction

endpackage

// File: rtl/afs_fault_cell.sv
module afs_fault_cell
  import amp_fault_pkg::*;
#(
  parameter recov_kind_e KIND     = REC_RESTART,
  parameter int unsigned HOLD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic active_o
);

  generate
    if (KIND == REC_TIMED) begin : g_timed
      localparam int unsigned CW = $clog2(HOLD_CYC + 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          act_d;
      logic          upd_en;

      always_comb begin
        act_d  = active_o;
        cnt_d  = cnt_q;
        upd_en = 1'b0;
        if (set_i) begin
          act_d  = 1'b1;
          cnt_d  = '0;
          upd_en = 1'b1;
        end else if (active_o && clr_i) begin
          upd_en = 1'b1;
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            act_d = 1'b0;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          active_o <= 1'b0;
          cnt_q    <= '0;
        end else if (upd_en) begin
          active_o <= act_d;
          cnt_q    <= cnt_d;
        end
      end
    end else begin : g_restart
      logic act_d;

      always_comb begin
        if (set_i)      act_d = 1'b1;
        else if (clr_i) act_d = 1'b0;
        else            act_d = active_o;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_o <= 1'b0;
        else        active_o <= act_d;
      end
    end
  endgenerate

endmodule

// File: rtl/afs_flag_bank.sv
module afs_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  logic [N-1:0] flags_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      flags_d[i] = set_i[i] | (flags_o[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flags_d;
  end

endmodule

// File: rtl/afs_gain_foldback.sv
module afs_gain_foldback #(
  parameter int unsigned GAIN_W   = 8,
  parameter int unsigned STEP_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warn_i,
  input  logic [GAIN_W-1:0] target_i,
  output logic [GAIN_W-1:0] gain_o
);

  localparam int unsigned PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [PW-1:0]     pre_q, pre_d;
  logic              tick;
  logic [GAIN_W-1:0] gain_d;
  logic              gain_en;

  assign tick = (pre_q == PW'(STEP_CYC - 1));

  always_comb begin
    pre_d = tick ? '0 : pre_q + 1'b1;
  end

  always_comb begin
    gain_d  = gain_o;
    gain_en = 1'b0;
    if (gain_o > target_i) begin
      gain_d  = target_i;
      gain_en = 1'b1;
    end else if (tick) begin
      if (warn_i && gain_o != '0) begin
        gain_d  = gain_o - 1'b1;
        gain_en = 1'b1;
      end else if (!warn_i && gain_o < target_i) begin
        gain_d  = gain_o + 1'b1;
        gain_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      gain_o <= '0;
    end else begin
      pre_q <= pre_d;
      if (gain_en) gain_o <= gain_d;
    end
  end

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
  import amp_fault_pkg::*;
#(
  parameter int unsigned GAIN_W    = 8,
  parameter int unsigned RECOV_CYC = 200,
  parameter int unsigned STEP_CYC  = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tw_hot_i,
  input  logic                  ot_hot_i,
  input  logic                  oc_i,
  input  logic                  ov_i,
  input  logic                  vdd_low_i,
  input  logic                  rail_low_i,
  input  logic                  od_temp_i,
  input  logic                  win_i,
  input  logic                  pll_unlock_i,
  input  logic                  pll_slow_i,
  input  logic [NUM_FAULTS-1:0] flag_clr_i,
  input  logic [GAIN_W-1:0]     vol_set_i,
  output logic                  diag_pull_low_o,
  output logic                  out_float_o,
  output logic [NUM_FAULTS-1:0] flags_o,
  output logic [GAIN_W-1:0]     gain_o
);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // trigger and restart conditions per fault class
  logic [NUM_FAULTS-1:0] trig_v, rest_v, act_v;
  logic                  supply_ok;

  assign supply_ok = ~vdd_low_i & ~rail_low_i;

  always_comb begin
    trig_v[FI_OT]    = ot_hot_i;
    rest_v[FI_OT]    = ~ot_hot_i;
    trig_v[FI_OC]    = oc_i;
    rest_v[FI_OC]    = ~oc_i;
    trig_v[FI_OV]    = ov_i;
    rest_v[FI_OV]    = supply_ok;
    trig_v[FI_UV]    = vdd_low_i | rail_low_i;
    rest_v[FI_UV]    = supply_ok;
    trig_v[FI_OD]    = od_temp_i & oc_i;
    rest_v[FI_OD]    = ~od_temp_i | ~oc_i;
    trig_v[FI_WIN]   = win_i;
    rest_v[FI_WIN]   = ~win_i;
    trig_v[FI_LOCK]  = pll_unlock_i;
    rest_v[FI_LOCK]  = ~pll_unlock_i;
    trig_v[FI_UFREQ] = pll_slow_i;
    rest_v[FI_UFREQ] = ~pll_slow_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FAULTS; gi++) begin : g_fault
      afs_fault_cell #(
        .KIND     (kind_of(gi)),
        .HOLD_CYC (RECOV_CYC)
      ) u_cell (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .set_i    (trig_v[gi]),
        .clr_i    (rest_v[gi]),
        .active_o (act_v[gi])
      );
    end
  endgenerate

  assign diag_pull_low_o = |(act_v & DIAG_ROUTE);
  assign out_float_o     = |act_v;

  afs_flag_bank #(
    .N (NUM_FAULTS)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (trig_v),
    .clr_i   (flag_clr_i),
    .flags_o (flags_o)
  );

  afs_gain_foldback #(
    .GAIN_W   (GAIN_W),
    .STEP_CYC (STEP_CYC)
  ) u_fold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .warn_i   (tw_hot_i),
    .target_i (vol_set_i),
    .gain_o   (gain_o)
  );

endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int unsigned GAIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ot_hot_i,
  input logic              oc_i,
  input logic              od_temp_i,
  input logic              pll_unlock_i,
  input logic [7:0]        flag_clr_i,
  input logic [GAIN_W-1:0] vol_set_i,
  input logic              diag_pull_low_o,
  input logic              out_float_o,
  input logic [7:0]        flags_o,
  input logic [GAIN_W-1:0] gain_o
);

  // becomes 1 once $past() refers to a functional cycle
  logic [2:0] live_q;
  logic       past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 3'b000;
    else        live_q <= {live_q[1:0], 1'b1};
  end
  assign past_ok = live_q[2];

  // R6
  diag_implies_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_pull_low_o |-> out_float_o);

  // R2
  ot_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ot_hot_i) |-> out_float_o && diag_pull_low_o && flags_o[0]);

  // R4
  od_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(od_temp_i && oc_i) |-> diag_pull_low_o && flags_o[4]);

  // R5
  lock_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(pll_unlock_i) |-> out_float_o && flags_o[6]);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(flags_o) & ~$past(flag_clr_i) & ~flags_o) == 8'h00));

  // R10
  gain_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> gain_o <= $past(vol_set_i));

  // R10
  gain_unit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (gain_o > $past(gain_o)) |-> gain_o == GAIN_W'($past(gain_o) + 1'b1));

endmodule

bind amp_fault_supervisor afs_checker #(
  .GAIN_W (GAIN_W)
) u_afs_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ot_hot_i        (ot_hot_i),
  .oc_i            (oc_i),
  .od_temp_i       (od_temp_i),
  .pll_unlock_i    (pll_unlock_i),
  .flag_clr_i      (flag_clr_i),
  .vol_set_i       (vol_set_i),
  .diag_pull_low_o (diag_pull_low_o),
  .out_float_o     (out_float_o),
  .flags_o         (flags_o),
  .gain_o          (gain_o)
);

// File: tb/tb_amp_fault_supervisor.sv
`timescale 1ns/1ps
module tb_amp_fault_supervisor;

  localparam int unsigned GW = 6;
  localparam int unsigned RC = 8;
  localparam int unsigned SC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tw, ot, oc, ov, vlow, rlow, odt, win, unlk, slow;
  logic [7:0]    clr;
  logic [GW-1:0] vol;
  logic          diag, flt;
  logic [7:0]    flags;
  logic [GW-1:0] gain;

  always #2.5 clk = ~clk;

  amp_fault_supervisor #(.GAIN_W(GW), .RECOV_CYC(RC), .STEP_CYC(SC)) dut (
    .clk(clk), .rst_n(rst_n), .tw_hot_i(tw), .ot_hot_i(ot), .oc_i(oc), .ov_i(ov),
    .vdd_low_i(vlow), .rail_low_i(rlow), .od_temp_i(odt), .win_i(win),
    .pll_unlock_i(unlk), .pll_slow_i(slow), .flag_clr_i(clr), .vol_set_i(vol),
    .diag_pull_low_o(diag), .out_float_o(flt), .flags_o(flags), .gain_o(gain));

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  // ---------------- reference model from the requirements
  logic [1:0]    m_rs;
  logic [7:0]    m_act, m_flags;
  int            m_cnt [2];
  logic [GW-1:0] m_gain;
  int            m_pre;

  function automatic logic [7:0] trig_of();
    logic [7:0] t;
    t[0] = ot; t[1] = oc; t[2] = ov; t[3] = vlow | rlow; t[4] = odt & oc;
    t[5] = win; t[6] = unlk; t[7] = slow;
    return t;
  endfunction

  function automatic logic [7:0] rest_of();
    logic [7:0] r;
    logic sok;
    sok = !vlow && !rlow;
    r[0] = !ot; r[1] = !oc; r[2] = sok; r[3] = sok; r[4] = !odt || !oc;
    r[5] = !win; r[6] = !unlk; r[7] = !slow;
    return r;
  endfunction

  task automatic model_step();
    logic [7:0] t, r;
    bit tick;
    t = trig_of();
    r = rest_of();
    for (int i = 0; i < 2; i++) begin            // R2 timed recovery
      if (t[i]) begin m_act[i] = 1'b1; m_cnt[i] = 0; end
      else if (m_act[i]) begin
        if (m_cnt[i] == RC - 1) begin m_act[i] = 1'b0; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
    end
    for (int i = 2; i < 8; i++) begin            // R3 R4 R5 restart
      if (t[i]) m_act[i] = 1'b1;
      else if (r[i]) m_act[i] = 1'b0;
    end
    m_flags = t | (m_flags & ~clr);              // R8
    tick = (m_pre == SC - 1);                    // R9 R10
    m_pre = tick ? 0 : m_pre + 1;
    if (m_gain > vol) m_gain = vol;
    else if (tick) begin
      if (tw && m_gain != 0) m_gain = m_gain - 1'b1;
      else if (!tw && m_gain < vol) m_gain = m_gain + 1'b1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 2'b00; m_act = '0; m_flags = '0; m_gain = '0; m_pre = 0;
      m_cnt[0] = 0; m_cnt[1] = 0;
    end else if (!m_rs[1]) m_rs = {m_rs[0], 1'b1};
    else model_step();
  end

  // ---------------- checking
  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R6", "diag", int'(diag), int'(|(m_act & 8'h3f)));
      check("R7", "float", int'(flt), int'(|m_act));
      check("R8", "flags", int'(flags), int'(m_flags));
      check("R9/R10", "gain", int'(gain), int'(m_gain));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    {tw, ot, oc, ov, vlow, rlow, odt, win, unlk, slow} = '0;
    clr = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    vol = '0;
    #1 rst_n = 1'b0;
    idle(3);
    tag = "R1";
    check("R1", "diag in reset", int'(diag), 0);
    check("R1", "float in reset", int'(flt), 0);
    check("R1", "flags in reset", int'(flags), 0);
    check("R1", "gain in reset", int'(gain), 0);
    ot = 1'b1; oc = 1'b1;            // ignored until internal release
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "float during release", int'(flt), 0);
    @(negedge clk);
    check("R1", "flags during release", int'(flags), 0);
    quiet();
    cmp_on = 1'b1;
    idle(3);

    // R2 timed recovery, with a re-assertion during the wait
    tag = "R2";
    ot = 1'b1; idle(3); ot = 1'b0;
    idle(RC - 1);
    check("R2", "ot still held", int'(flt), 1);
    @(negedge clk);
    check("R2", "ot released", int'(flt), 0);
    oc = 1'b1; idle(2); oc = 1'b0; idle(4);
    oc = 1'b1; @(negedge clk); oc = 1'b0;
    idle(RC - 1);
    check("R2", "oc count restarted", int'(flt), 1);
    idle(2);
    check("R2", "oc released", int'(flt), 0);

    // R3 overvoltage hold while supply is low
    tag = "R3";
    ov = 1'b1; vlow = 1'b1; idle(2); ov = 1'b0; idle(4);
    check("R3", "ov held while low", int'(diag), 1);
    vlow = 1'b0; rlow = 1'b1; idle(2);
    check("R3", "rail low keeps fault", int'(flt), 1);
    rlow = 1'b0; idle(2);
    check("R3", "supply good clears", int'(flt), 0);

    // R4 overdissipation needs both conditions
    tag = "R4";
    odt = 1'b1; idle(3);
    check("R4", "temp alone", int'(flt), 0);
    oc = 1'b1; odt = 1'b1; @(negedge clk); odt = 1'b0; oc = 1'b0;
    idle(RC + 2);
    check("R4", "od cleared", int'(flt), 0);

    // R5 PLL faults float but do not pull diag
    tag = "R5";
    unlk = 1'b1; @(negedge clk);
    check("R5", "unlock floats", int'(flt), 1);
    check("R6", "unlock no diag", int'(diag), 0);
    unlk = 1'b0; slow = 1'b1; win = 1'b1; idle(2);
    check("R6", "window pulls diag", int'(diag), 1);
    slow = 1'b0; win = 1'b0; idle(2);
    check("R7", "all clear", int'(flt), 0);

    // R8 clear strobe, set wins
    tag = "R8";
    ot = 1'b1; clr = 8'hff; @(negedge clk); clr = '0;
    check("R8", "set beats clear", int'(flags[0]), 1);
    ot = 1'b0; idle(RC + 2);
    clr = 8'hff; @(negedge clk); clr = '0;
    check("R8", "flags cleared", int'(flags), 0);

    // R9 R10 foldback
    tag = "R10";
    vol = GW'(20); idle(SC * 22);
    check("R10", "ramp reaches setting", int'(gain), 20);
    tag = "R9";
    tw = 1'b1; idle(SC * 3);
    check("R9", "gain folded", int'(gain < GW'(20)), 1);
    check("R7", "warning never floats", int'(flt), 0);
    idle(SC * 22);
    check("R9", "gain floor", int'(gain), 0);
    tw = 1'b0; tag = "R10"; idle(SC * 22);
    check("R10", "gain restored", int'(gain), 20);
    vol = GW'(5); @(negedge clk);
    check("R10", "clamp to lower setting", int'(gain), 5);

    // random phase
    tag = "R2-random";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 16 == 0) ot = ~ot;
      if ($urandom % 16 == 0) oc = ~oc;
      if ($urandom % 24 == 0) ov = ~ov;
      if ($urandom % 24 == 0) vlow = ~vlow;
      if ($urandom % 32 == 0) rlow = ~rlow;
      if ($urandom % 16 == 0) odt = ~odt;
      if ($urandom % 16 == 0) win = ~win;
      if ($urandom % 16 == 0) unlk = ~unlk;
      if ($urandom % 16 == 0) slow = ~slow;
      if ($urandom % 48 == 0) tw = ~tw;
      if ($urandom % 200 == 0) vol = GW'($urandom);
      clr = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
      @(negedge clk);
    end
    quiet();
    idle(RC + 4);
    check("R7", "quiet after random", int'(flt), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule